// File: doc/BRIEF.md
# Keyed Watchdog Timer with Write-Once Configuration

This block is a bus-attached watchdog. A 12-bit down-counter is decremented once for every 128 pulses of a slow-clock enable, so at a 32.768 kHz slow clock it steps at 256 Hz and the longest period is 16 s. Firmware must keep the counter from running out by issuing a restart, which is a control write that has to carry an 8-bit key and is honoured only while the counter has already fallen to or below a programmable window threshold. If the counter runs out, a flag is raised and, when enabled, a 16-cycle reset request is driven on either the full-system or the processor-only reset output.

The configuration register can be written exactly once after reset. After that write it is frozen, so runaway code cannot stop or stretch the watchdog. The configuration can also disable the watchdog, or freeze it while an external debug-halt input is high. A status register reports expiry and window violations together with the live counter value. Reading it clears the flags.

Bus access is one cycle: a write takes effect at the clock edge where `bus_we_i` is high. Read data is registered and valid in the cycle after the edge where `bus_re_i` is high.

Top module: `wdt_keyed_top`

## Requirements
- R1: The first write to address 1 after reset is stored in the mode register. Every later write to address 1 leaves it unchanged until reset. Mode reads back at address 1 as bit 28 disable, bit 27 debug-hold, bit 26 error-reset enable, bit 25 processor-only, bit 24 reset enable, bits [23:12] window threshold, bits [11:0] reload value. After reset the mode register is 32'h01FF_FFFF.
- R2: The counter is 12 bits wide. It decrements by one for each 128 cycles in which `slow_tick_i` is high.
- R3: A write to address 0 with bits [31:24] = 8'hA5 and bit 0 = 1 is a restart. A legal restart reloads the counter from the reload field and clears the prescaler. A write with any other key, or with bit 0 clear, has no effect.
- R4: A decrement step that arrives while the counter is 0 is an expiry, so expiry happens (reload + 1) × 128 slow ticks after a reload. An expiry sets the expiry flag.
- R5: While the disable bit is set, the counter and prescaler hold, and neither reset output is ever asserted.
- R6: On expiry with reset enable set, a reset request is raised. It appears on `cpu_rst_o` when the processor-only bit is set, and on `sys_rst_o` otherwise. With reset enable clear, the counter reloads at once and no request is raised.
- R7: While the debug-hold bit is set and `dbg_halt_i` is high, the counter and prescaler hold. Counting resumes when the input falls.
- R8: A restart while the counter is above the window threshold does not reload the counter and sets the window-error flag. If error-reset enable is set, it also raises a reset request with the same target selection as R6.
- R9: Status reads at address 2 as bit 0 expiry flag, bit 1 window-error flag, bits [27:16] counter, and all other bits 0. A status read clears both flags, but a flag set in the same cycle stays set.
- R10: A reset request is exactly 16 clock cycles long. While it is active the counter is frozen, and at its end the counter reloads from the reload field.
- R11: The accepted mode write also reloads the counter from the new reload value and clears the prescaler.
- R12: A legal restart in the same cycle as an expiry step wins: the counter reloads, and neither the expiry flag nor a reset request is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick_i | input | 1 | Slow-clock enable, one system cycle per slow-clock period |
| dbg_halt_i | input | 1 | Debugger halt indication |
| bus_addr_i | input | 2 | Register address: 0 control, 1 mode, 2 status |
| bus_we_i | input | 1 | Write strobe |
| bus_re_i | input | 1 | Read strobe; reading status clears its flags |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| sys_rst_o | output | 1 | Full-system reset request |
| cpu_rst_o | output | 1 | Processor-only reset request |

## Verification
A keyed restart can land on the same edge as the decrement step that would expire the counter. The bench sets a reload value of zero and times a restart to hit exactly the 128th edge after the mode write. It then checks that the status shows no expiry flag and that no reset output rises, which would only be true if the restart had priority. It also checks that the next expiry comes a full 128 edges later, which shows the reload really took place at the collision edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int CNT_W = 12;
    localparam logic [7:0] RESTART_KEY = 8'hA5;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_MODE = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    typedef struct packed {
        logic             wd_off;
        logic             dbg_hold;
        logic             err_rst_en;
        logic             cpu_only;
        logic             rst_en;
        logic [CNT_W-1:0] delta;
        logic [CNT_W-1:0] reload;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    typedef struct packed {
        logic win_err;
        logic expired;
    } flags_t;

    localparam mode_t MODE_DEFAULT = '{
        wd_off:     1'b0,
        dbg_hold:   1'b0,
        err_rst_en: 1'b0,
        cpu_only:   1'b0,
        rst_en:     1'b1,
        delta:      {CNT_W{1'b1}},
        reload:     {CNT_W{1'b1}}
    };

    function automatic mode_t decode_mode(input logic [31:0] d);
        return mode_t'(d[MODE_W-1:0]);
    endfunction

    function automatic logic key_ok(input logic [31:0] d);
        return (d[31:24] == RESTART_KEY) && d[0];
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int DIV = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    input  logic slow_tick,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] pre;

    assign tick = run && slow_tick && (pre == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear)
            pre <= '0;
        else if (run && slow_tick)
            pre <= tick ? '0 : pre + 1'b1;
    end

    // R2: a step always restarts the division from zero
    a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
        (tick && !clear) |=> (pre == '0));

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       bus_addr,
    input  logic             bus_we,
    input  logic             bus_re,
    input  logic [31:0]      bus_wdata,
    input  logic             expire_ev,
    input  logic             win_err_ev,
    input  logic [CNT_W-1:0] cnt,
    output mode_t            mode,
    output mode_t            mode_new,
    output logic             mode_load,
    output logic             restart_req,
    output logic [31:0]      bus_rdata
);
    logic   locked;
    flags_t flags;
    logic   stat_rd;

    assign mode_new    = decode_mode(bus_wdata);
    assign mode_load   = bus_we && (bus_addr == ADDR_MODE) && !locked;
    assign restart_req = bus_we && (bus_addr == ADDR_CTRL) && key_ok(bus_wdata);
    assign stat_rd     = bus_re && (bus_addr == ADDR_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= MODE_DEFAULT;
            locked <= 1'b0;
        end else if (mode_load) begin
            mode   <= mode_new;
            locked <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            if (expire_ev)       flags.expired <= 1'b1;
            else if (stat_rd)    flags.expired <= 1'b0;
            if (win_err_ev)      flags.win_err <= 1'b1;
            else if (stat_rd)    flags.win_err <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_re) begin
            case (bus_addr)
                ADDR_MODE: bus_rdata <= {{(32-MODE_W){1'b0}}, mode};
                ADDR_STAT: bus_rdata <= {4'b0, cnt, 14'b0, flags};
                default:   bus_rdata <= '0;
            endcase
        end
    end

    // R1: once locked, the mode register never changes until reset
    a_r1_locked_mode: assert property (@(posedge clk) disable iff (rst)
        (locked && !rst) |=> $stable(mode));

    // R9: a status read with no new expiry leaves the expiry flag clear
    a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
        (!rst && stat_rd && !expire_ev) |=> !flags.expired);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int PULSE_LEN = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  mode_t            mode,
    input  mode_t            mode_new,
    input  logic             mode_load,
    input  logic             restart_req,
    input  logic             dbg_in,
    input  logic             tick,
    output logic             run,
    output logic             pre_clear,
    output logic [CNT_W-1:0] cnt,
    output logic             expire_ev,
    output logic             win_err_ev,
    output logic             sys_rst,
    output logic             cpu_rst
);
    localparam int PW = $clog2(PULSE_LEN + 1);
    localparam logic [PW-1:0] PLEN = PW'(PULSE_LEN);

    logic [PW-1:0] pulse_cnt;
    logic          tgt_cpu;
    logic          busy, halted, in_window, restart_ok, restart_bad, fire;

    assign busy        = (pulse_cnt != '0);
    assign halted      = mode.dbg_hold && dbg_in;
    assign run         = !mode.wd_off && !halted && !busy;
    assign in_window   = (cnt <= mode.delta);
    assign restart_ok  = restart_req && !busy && in_window;
    assign restart_bad = restart_req && !busy && !in_window;
    assign expire_ev   = tick && (cnt == '0) && !restart_ok;
    assign win_err_ev  = restart_bad;
    assign fire        = !mode.wd_off &&
                         ((expire_ev && mode.rst_en) || (restart_bad && mode.err_rst_en));
    assign pre_clear   = mode_load || restart_ok || busy;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= MODE_DEFAULT.reload;
        else if (mode_load)
            cnt <= mode_new.reload;
        else if (restart_ok)
            cnt <= mode.reload;
        else if (busy) begin
            if (pulse_cnt == PW'(1)) cnt <= mode.reload;
        end else if (expire_ev) begin
            if (!fire) cnt <= mode.reload;
        end else if (tick)
            cnt <= cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_cnt <= '0;
            tgt_cpu   <= 1'b0;
        end else if (fire) begin
            pulse_cnt <= PLEN;
            tgt_cpu   <= mode.cpu_only;
        end else if (busy) begin
            pulse_cnt <= pulse_cnt - 1'b1;
        end
    end

    assign sys_rst = busy && !tgt_cpu;
    assign cpu_rst = busy && tgt_cpu;

    // R2: an ordinary step lowers the counter by exactly one
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (!rst && tick && (cnt != '0) && !restart_ok && !mode_load)
        |=> (cnt == $past(cnt) - 1'b1));

    // R3: a legal restart leaves the reload value in the counter
    a_r3_restart_loads: assert property (@(posedge clk) disable iff (rst)
        (!rst && restart_ok && !mode_load) |=> (cnt == $past(mode.reload)));

    // R5: a disabled watchdog never starts a request
    a_r5_off_quiet: assert property (@(posedge clk) disable iff (rst)
        (!rst && mode.wd_off && !busy) |=> !(sys_rst || cpu_rst));

    // R7: debug hold freezes the count
    a_r7_dbg_freeze: assert property (@(posedge clk) disable iff (rst)
        (!rst && halted && !busy && !restart_req && !mode_load) |=> $stable(cnt));

    // R10: the counter holds the reload value as the request ends
    a_r10_reload_after: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(busy)) |-> (cnt == $past(mode.reload)));

endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top
    import wdt_pkg::*;
#(
    parameter int PRESCALE  = 128,
    parameter int PULSE_LEN = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        slow_tick_i,
    input  logic        dbg_halt_i,
    input  logic [1:0]  bus_addr_i,
    input  logic        bus_we_i,
    input  logic        bus_re_i,
    input  logic [31:0] bus_wdata_i,
    output logic [31:0] bus_rdata_o,
    output logic        sys_rst_o,
    output logic        cpu_rst_o
);
    mode_t            mode, mode_new;
    logic             mode_load, restart_req;
    logic             run, pre_clear, tick;
    logic [CNT_W-1:0] cnt;
    logic             expire_ev, win_err_ev;

    wdt_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr_i),
        .bus_we     (bus_we_i),
        .bus_re     (bus_re_i),
        .bus_wdata  (bus_wdata_i),
        .expire_ev  (expire_ev),
        .win_err_ev (win_err_ev),
        .cnt        (cnt),
        .mode       (mode),
        .mode_new   (mode_new),
        .mode_load  (mode_load),
        .restart_req(restart_req),
        .bus_rdata  (bus_rdata_o)
    );

    wdt_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .clear    (pre_clear),
        .run      (run),
        .slow_tick(slow_tick_i),
        .tick     (tick)
    );

    wdt_counter #(.PULSE_LEN(PULSE_LEN)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .mode_new   (mode_new),
        .mode_load  (mode_load),
        .restart_req(restart_req),
        .dbg_in     (dbg_halt_i),
        .tick       (tick),
        .run        (run),
        .pre_clear  (pre_clear),
        .cnt        (cnt),
        .expire_ev  (expire_ev),
        .win_err_ev (win_err_ev),
        .sys_rst    (sys_rst_o),
        .cpu_rst    (cpu_rst_o)
    );

    // R6: the two request outputs never rise together
    a_r6_one_target: assert property (@(posedge clk) disable iff (rst)
        !(sys_rst_o && cpu_rst_o));

endmodule

// File: tb/wdt_keyed_top_tb.sv
module wdt_keyed_top_tb;
    localparam time CYC = 20ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slow_tick = 1'b1;
    logic        half_rate = 1'b0;
    logic        dbg_halt = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sys_rst, cpu_rst;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CYC/2) clk = ~clk;

    always @(negedge clk) slow_tick <= half_rate ? ~slow_tick : 1'b1;

    wdt_keyed_top u_dut (
        .clk(clk), .rst(rst), .slow_tick_i(slow_tick), .dbg_halt_i(dbg_halt),
        .bus_addr_i(bus_addr), .bus_we_i(bus_we), .bus_re_i(bus_re),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .sys_rst_o(sys_rst), .cpu_rst_o(cpu_rst)
    );

    function automatic logic [31:0] mk_mode(input bit off, dbg, err, cpu, en,
                                            input logic [11:0] delta, reload);
        return {3'b0, off, dbg, err, cpu, en, delta, reload};
    endfunction

    function automatic logic [31:0] stat_val(input logic [11:0] c, input bit win, exp);
        return {4'b0, c, 14'b0, win, exp};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a negedge; the access lands on the following posedge
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        half_rate = 1'b0; dbg_halt = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        do_reset();
        chk("R1 reset outputs", {30'b0, sys_rst, cpu_rst}, 32'h0);
        rd(2'd1, d);
        chk("R1 default mode", d, 32'h01FF_FFFF);
        rd(2'd2, d);
        chk("R9 reset status", d, stat_val(12'hFFF, 1'b0, 1'b0));
    endtask

    task automatic t_lock();
        logic [31:0] d;
        do_reset();
        wr(2'd1, mk_mode(0, 0, 0, 0, 1, 12'hFFF, 12'd5));
        wr(2'd1, mk_mode(1, 1, 1, 1, 0, 12'h001, 12'd77));
        rd(2'd1, d);
        chk("R1 second mode write ignored", d, mk_mode(0, 0, 0, 0, 1, 12'hFFF, 12'd5));
        rd(2'd2, d);
        chk("R11 mode write reloads", d, stat_val(12'd5, 1'b0, 1'b0));
    endtask

    task automatic t_key();
        logic [31:0] d;
        do_reset();
        wr(2'd1, mk_mode(0, 0, 0, 0, 1, 12'hFFF, 12'd9));   // P0
        repeat (299) @(negedge clk);                         // n300
        wr(2'd0, 32'h5A00_0001);                             // P300 wrong key
        rd(2'd2, d);
        chk("R2/R3 wrong key ignored", d, stat_val(12'd7, 1'b0, 1'b0));
        wr(2'd0, 32'hA500_0000);                             // key, bit0 clear
        rd(2'd2, d);
        chk("R3 restart bit clear ignored", d, stat_val(12'd7, 1'b0, 1'b0));
        wr(2'd0, 32'hA500_0001);
        rd(2'd2, d);
        chk("R3 keyed restart reloads", d, stat_val(12'd9, 1'b0, 1'b0));
    endtask

    task automatic t_expire_sys();
        logic [31:0] d;
        do_reset();
        wr(2'd1, mk_mode(0, 0, 0, 0, 1, 12'hFFF, 12'd1));   // P0, expiry at P256
        repeat (255) @(negedge clk);                         // n256
        chk("R4 no request before expiry", {31'b0, sys_rst}, 32'd0);
        @(negedge clk);
        chk("R6 system request on expiry", {30'b0, sys_rst, cpu_rst}, 32'd2);
        repeat (15) @(negedge clk);
        chk("R10 request still high at cycle 16", {31'b0, sys_rst}, 32'd1);
        @(negedge clk);
        chk("R10 request ends after 16 cycles", {31'b0, sys_rst}, 32'd0);
        rd(2'd2, d);
        chk("R4/R10 flag set and counter reloaded", d, stat_val(12'd1, 1'b0, 1'b1));
        rd(2'd2, d);
        chk("R9 read clears flags", d, stat_val(12'd1, 1'b0, 1'b0));
    endtask

    task automatic t_expire_cpu();
        do_reset();
        wr(2'd1, mk_mode(0, 0, 0, 1, 1, 12'hFFF, 12'd0));   // expiry at P128
        repeat (127) @(negedge clk);
        chk("R6 cpu request low before expiry", {31'b0, cpu_rst}, 32'd0);
        @(negedge clk);
        chk("R6 processor-only target", {30'b0, sys_rst, cpu_rst}, 32'd1);
    endtask

    task automatic t_no_rst_en();
        logic [31:0] d;
        int hits = 0;
        do_reset();
        wr(2'd1, mk_mode(0, 0, 0, 0, 0, 12'hFFF, 12'd0));
        repeat (400) begin
            @(negedge clk);
            if (sys_rst || cpu_rst) hits++;
        end
        chk("R6 no request without enable", hits, 0);
        rd(2'd2, d);
        chk("R4/R6 expiry flagged, counter reloaded", d, stat_val(12'd0, 1'b0, 1'b1));
    endtask

    task automatic t_disabled();
        logic [31:0] d;
        int hits = 0;
        do_reset();
        wr(2'd1, mk_mode(1, 0, 1, 0, 1, 12'hFFF, 12'd0));
        repeat (400) begin
            @(negedge clk);
            if (sys_rst || cpu_rst) hits++;
        end
        chk("R5 disabled never requests", hits, 0);
        rd(2'd2, d);
        chk("R5 disabled counter holds", d, stat_val(12'd0, 1'b0, 1'b0));
    endtask

    task automatic t_debug();
        logic [31:0] d;
        do_reset();
        dbg_halt = 1'b1;
        wr(2'd1, mk_mode(0, 1, 0, 0, 1, 12'hFFF, 12'd9));
        repeat (400) @(negedge clk);
        rd(2'd2, d);
        chk("R7 debug halt holds counter", d, stat_val(12'd9, 1'b0, 1'b0));
        dbg_halt = 1'b0;
        repeat (140) @(negedge clk);
        rd(2'd2, d);
        chk("R7 counting resumes", d, stat_val(12'd8, 1'b0, 1'b0));
    endtask

    task automatic t_window();
        logic [31:0] d;
        do_reset();
        wr(2'd1, mk_mode(0, 0, 0, 0, 1, 12'd3, 12'd5));     // P0, cnt=5
        wr(2'd0, 32'hA500_0001);                             // P1, 5 > 3
        chk("R8 early restart raises no request", {30'b0, sys_rst, cpu_rst}, 32'd0);
        rd(2'd2, d);
        chk("R8 early restart flagged, no reload", d, stat_val(12'd5, 1'b1, 1'b0));
        repeat (297) @(negedge clk);                         // n300, cnt=3
        wr(2'd0, 32'hA500_0001);
        rd(2'd2, d);
        chk("R8 restart at threshold accepted", d, stat_val(12'd5, 1'b0, 1'b0));
    endtask

    task automatic t_window_reset();
        logic [31:0] d;
        do_reset();
        wr(2'd1, mk_mode(0, 0, 1, 1, 0, 12'd3, 12'd5));     // P0
        wr(2'd0, 32'hA500_0001);                             // P1, violation
        chk("R8 error reset to processor", {30'b0, sys_rst, cpu_rst}, 32'd1);
        repeat (18) @(negedge clk);
        chk("R10 error request finished", {30'b0, sys_rst, cpu_rst}, 32'd0);
        rd(2'd2, d);
        chk("R8/R10 window flag, counter reloaded", d, stat_val(12'd5, 1'b1, 1'b0));
    endtask

    task automatic t_collision();
        logic [31:0] d;
        int hits = 0;
        do_reset();
        wr(2'd1, mk_mode(0, 0, 0, 0, 1, 12'hFFF, 12'd0));   // P0, expiry due P128
        repeat (127) @(negedge clk);                         // n128
        wr(2'd0, 32'hA500_0001);                             // P128
        if (sys_rst || cpu_rst) hits++;
        rd(2'd2, d);                                         // P129
        if (sys_rst || cpu_rst) hits++;
        chk("R12 restart beats expiry: no flag", d, stat_val(12'd0, 1'b0, 1'b0));
        chk("R12 restart beats expiry: no request", hits, 0);
        repeat (126) @(negedge clk);                         // n256
        chk("R12 next expiry not early", {31'b0, sys_rst}, 32'd0);
        @(negedge clk);                                      // n257
        chk("R12 next expiry a full period later", {31'b0, sys_rst}, 32'd1);
    endtask

    task automatic t_half_rate();
        do_reset();
        half_rate = 1'b1;
        wr(2'd1, mk_mode(0, 0, 0, 0, 1, 12'hFFF, 12'd0));
        repeat (249) @(negedge clk);
        chk("R2 half-rate slow ticks: not yet expired", {31'b0, sys_rst}, 32'd0);
        repeat (14) @(negedge clk);
        chk("R2 half-rate slow ticks: expired after 128 ticks", {31'b0, sys_rst}, 32'd1);
        half_rate = 1'b0;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset_state();
        t_lock();
        t_key();
        t_expire_sys();
        t_expire_cpu();
        t_no_rst_en();
        t_disabled();
        t_debug();
        t_window();
        t_window_reset();
        t_collision();
        t_half_rate();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CYC * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule